// File: doc/BRIEF.md
# Bus-mapped interval timer with interrupt flags

This block is the first timer of a classic eight-bit peripheral adapter, together with the interrupt flag and enable registers that turn its expiry into an active-low interrupt request. A processor reaches it through an eight-bit register window. Only the four lowest address bits select a register, so the sixteen registers repeat across the whole chip-select window. The block sits on the CPU bus clock. Its countdown is paced by a separate timer clock, whose rising edges pass through a two-flop synchroniser and become single-cycle count enables in the bus domain.

Software fills a sixteen-bit reload value one byte at a time. Writing the upper counter byte copies that value into the down counter and starts a run. When a count enable arrives with the counter at zero, the block either reloads from the stored value and raises its flag again on every pass (free-run), or raises the flag once and lets the counter wrap and keep falling (one-shot). Bit 6 of the auxiliary control register picks the mode. Software clears the flag by reading the low counter byte, by writing a 1 to the flag bit, or by starting a new run. The port, direction, second-timer, shift and peripheral-control offsets act as plain storage bytes.

Top module: `via_timer1`

## Requirements
- R1: After reset, the counter and the stored reload value read 0x00. The flag register reads 0x00, the enable register reads 0x80, and irq_n is 1.
- R2: Only addr[3:0] selects a register. Any address with the same low nibble reaches the same register for both read and write (e.g. 0x34 acts as 0x04, 0xA4 as 0x04, 0x10 as 0x00).
- R3: A write to offset 4 or offset 6 sets the low byte of the reload value, and a write to offset 7 sets its high byte. Offsets 6 and 7 read the reload value back. None of these writes changes the counter.
- R4: A write to offset 5 sets the high byte of the reload value and loads the counter with {written byte, reload low byte}. It arms a one-shot run and clears flag bit 6.
- R5: The counter falls by one for each rising edge of tmr_clk. Offset 4 reads its low byte and offset 5 its high byte.
- R6: With offset 11 bit 6 = 1 (free-run), a count step taken at zero reloads the counter from the reload value and sets flag bit 6 (offset 13). The period is reload+1 timer edges, and it repeats.
- R7: With offset 11 bit 6 = 0 (one-shot), the first count step at zero after a start sets flag bit 6. The counter wraps to 0xFFFF and keeps falling, and later wraps set no flag until the next write to offset 5.
- R8: A read of offset 4 clears flag bit 6. Reads of other offsets leave it set.
- R9: A write to offset 13 clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R10: A write to offset 14 with bit 7 = 1 sets the enable bits given by data bits 6..0. With bit 7 = 0 it clears them. Offset 14 reads with bit 7 = 1.
- R11: Flag register bit 7 reads 1 exactly when a set flag has its enable bit set, and irq_n is 0 exactly then.
- R12: Offsets 0-3, 8-10, 11, 12 and 15 read back the last byte written to them, and writing them does not disturb the counter or irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | CPU bus clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_clk | input | 1 | Independent timer clock; each rising edge is one count step |
| cs | input | 1 | Chip select for the register window |
| addr | input | ADDR_W | Register address; only bits 3..0 are decoded |
| rd_en | input | 1 | Read strobe; read side effects take place at the bus clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with ADDR_W = 8 and SYNC_STAGES = 2. The eight-bit address covers the full 256-byte window, so mirrored addresses such as 0x34, 0x85, 0xA4 and 0xF6 can be tried against their base offsets. The bench drives the timer clock one edge at a time and leaves several bus cycles between edges for the two-stage synchroniser. Each count step is therefore deterministic, which makes the exact reload period, the one-shot wrap to 0xFFFF and a restart after expiry all observable through the register reads.

// File: rtl/via_t1_pkg.sv
package via_t1_pkg;
  localparam int DW    = 8;
  localparam int SEL_W = 4;
  localparam int NREG  = 1 << SEL_W;
  localparam int NSRC  = DW - 1;

  // register offsets that carry behaviour
  localparam logic [SEL_W-1:0] REG_CNT_LO  = 4'd4;
  localparam logic [SEL_W-1:0] REG_CNT_HI  = 4'd5;
  localparam logic [SEL_W-1:0] REG_LAT_LO  = 4'd6;
  localparam logic [SEL_W-1:0] REG_LAT_HI  = 4'd7;
  localparam logic [SEL_W-1:0] REG_AUX     = 4'd11;
  localparam logic [SEL_W-1:0] REG_FLAGS   = 4'd13;
  localparam logic [SEL_W-1:0] REG_ENABLES = 4'd14;

  localparam int MODE_BIT = 6;   // auxiliary register: 1 = free-run
  localparam int T1_BIT   = 6;   // flag / enable position of the timer

  // offsets that are plain storage bytes (auxiliary register included)
  localparam logic [NREG-1:0] STORE_MASK = 16'b1001_1111_0000_1111;
endpackage

// File: rtl/via_tick_sync.sv
module via_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb sync_d = {sync_q[STAGES-2:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/via_t1_core.sv
module via_t1_core
  import via_t1_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          lat_lo_we,
  input  logic          lat_hi_we,
  input  logic          start_we,
  input  logic [DW-1:0] wdata,
  input  logic          free_run,
  output logic [2*DW-1:0] count,
  output logic [2*DW-1:0] latch,
  output logic          armed,
  output logic          flag_set
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] count_q, count_d;
  logic [CW-1:0] latch_q, latch_d;
  logic          armed_q, armed_d;
  logic          underflow;

  always_comb begin
    latch_d = latch_q;
    if (lat_lo_we) latch_d[DW-1:0]  = wdata;
    if (lat_hi_we) latch_d[CW-1:DW] = wdata;
  end

  // a start write takes the cycle; a coinciding count step is dropped
  assign underflow = tick & ~start_we & (count_q == '0);

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    if (start_we) begin
      count_d = {wdata, latch_q[DW-1:0]};
      armed_d = 1'b1;
    end else if (tick) begin
      if (count_q == '0 && free_run) begin
        count_d = latch_q;
      end else begin
        count_d = count_q - CW'(1);
      end
      if (count_q == '0 && !free_run) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      latch_q <= '0;
      armed_q <= 1'b0;
    end else begin
      count_q <= count_d;
      latch_q <= latch_d;
      armed_q <= armed_d;
    end
  end

  assign flag_set = underflow & (free_run | armed_q);
  assign count    = count_q;
  assign latch    = latch_q;
  assign armed    = armed_q;
endmodule

// File: rtl/via_t1_irq.sv
module via_t1_irq
  import via_t1_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic            en_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   flags_rd,
  output logic [DW-1:0]   enables_rd,
  output logic            irq_n
);
  logic [NSRC-1:0] flag_q, flag_d;
  logic [NSRC-1:0] en_q, en_d;
  logic            any_active;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // a new event outranks a clear in the same cycle
    always_comb flag_d[i] = set_vec[i] | (flag_q[i] & ~clr_vec[i]);
    always_comb begin
      en_d[i] = en_q[i];
      if (en_we && wdata[i]) en_d[i] = wdata[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign any_active = |(flag_q & en_q);
  assign flags_rd   = {any_active, flag_q};
  assign enables_rd = {1'b1, en_q};
  assign irq_n      = ~any_active;
endmodule

// File: rtl/via_store.sv
module via_store
  import via_t1_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (STORE_MASK[i]) begin : g_keep
      logic [DW-1:0] q, d;
      always_comb d = (we && sel == SEL_W'(i)) ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign regs[i] = q;
    end else begin : g_none
      assign regs[i] = '0;
    end
  end
endmodule

// File: rtl/via_timer1.sv
module via_timer1
  import via_t1_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              tmr_clk,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_n
);
  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [SEL_W-1:0]        sel;
  logic                    wr_hit, rd_hit, start_we;
  logic                    tmr_tick;
  logic [2*DW-1:0]         t1_count, t1_latch;
  logic                    t1_armed, t1_flag_set, free_run;
  logic [NSRC-1:0]         set_vec, clr_vec;
  logic [DW-1:0]           flags_rd, enables_rd;
  logic [NREG-1:0][DW-1:0] store_regs;

  // reset: asserted at once, released on the bus clock
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign sel = addr[SEL_W-1:0];
  if (ADDR_W > SEL_W) begin : g_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr[ADDR_W-1:SEL_W];
  end

  assign wr_hit   = cs & wr_en;
  assign rd_hit   = cs & rd_en;
  assign start_we = wr_hit && sel == REG_CNT_HI;

  via_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(bus_clk), .rst_n(rst_sync_n), .async_in(tmr_clk), .tick(tmr_tick)
  );

  via_store u_store (
    .clk(bus_clk), .rst_n(rst_sync_n), .we(wr_hit), .sel(sel),
    .wdata(wdata), .regs(store_regs)
  );

  assign free_run = store_regs[REG_AUX][MODE_BIT];

  via_t1_core u_core (
    .clk(bus_clk), .rst_n(rst_sync_n), .tick(tmr_tick),
    .lat_lo_we(wr_hit && (sel == REG_CNT_LO || sel == REG_LAT_LO)),
    .lat_hi_we(wr_hit && (sel == REG_CNT_HI || sel == REG_LAT_HI)),
    .start_we(start_we), .wdata(wdata), .free_run(free_run),
    .count(t1_count), .latch(t1_latch), .armed(t1_armed),
    .flag_set(t1_flag_set)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[T1_BIT] = t1_flag_set;
    clr_vec         = '0;
    if (wr_hit && sel == REG_FLAGS) clr_vec = wdata[NSRC-1:0];
    if ((rd_hit && sel == REG_CNT_LO) || start_we) clr_vec[T1_BIT] = 1'b1;
  end

  via_t1_irq u_irq (
    .clk(bus_clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_we(wr_hit && sel == REG_ENABLES), .wdata(wdata),
    .flags_rd(flags_rd), .enables_rd(enables_rd), .irq_n(irq_n)
  );

  always_comb begin
    case (sel)
      REG_CNT_LO:  rdata = t1_count[DW-1:0];
      REG_CNT_HI:  rdata = t1_count[2*DW-1:DW];
      REG_LAT_LO:  rdata = t1_latch[DW-1:0];
      REG_LAT_HI:  rdata = t1_latch[2*DW-1:DW];
      REG_FLAGS:   rdata = flags_rd;
      REG_ENABLES: rdata = enables_rd;
      default:     rdata = store_regs[sel];
    endcase
  end
endmodule

// File: rtl/via_timer1_chk.sv
module via_timer1_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_hit,
  input logic        rd_hit,
  input logic [3:0]  sel,
  input logic [7:0]  wdata,
  input logic [15:0] count,
  input logic [15:0] latch,
  input logic        armed,
  input logic        free_run,
  input logic        t1_flag,
  input logic        t1_en,
  input logic        irq_n
);
  logic start;
  logic step;
  assign start = wr_hit && sel == 4'd5;
  assign step  = tick && !start;

  assert_load_copies_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == {$past(wdata), $past(latch[7:0])} && !t1_flag && armed);

  assert_count_steps_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && count != 16'h0000 |=> count == $past(count) - 16'h0001);

  assert_freerun_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && count == 16'h0000 && free_run |=> count == $past(latch) && t1_flag);

  assert_oneshot_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step && count == 16'h0000 && !free_run |=> !armed && count == 16'hFFFF);

  assert_flag_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t1_flag) |-> $past(armed || free_run));

  assert_read_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && sel == 4'd4 && !(step && count == 16'h0000) |=> !t1_flag);

  assert_enable_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && sel == 4'd14 && wdata[7] && wdata[6] |=> t1_en);

  assert_irq_fall_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> t1_flag && t1_en);

  assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> !(t1_flag && t1_en));
endmodule

bind via_timer1 via_timer1_chk u_chk (
  .clk(bus_clk), .rst_n(rst_sync_n), .tick(tmr_tick),
  .wr_hit(wr_hit), .rd_hit(rd_hit), .sel(sel), .wdata(wdata),
  .count(t1_count), .latch(t1_latch), .armed(t1_armed),
  .free_run(free_run), .t1_flag(flags_rd[6]), .t1_en(enables_rd[6]),
  .irq_n(irq_n)
);

// File: tb/via_timer1_test.sv
module via_timer1_test;
  logic       bus_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       tmr_clk = 1'b0;
  logic       cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_n;
  int         checks = 0, errors = 0;
  logic       done = 1'b0;

  always #10 bus_clk = ~bus_clk;   // 50 MHz

  via_timer1 #(.ADDR_W(8), .SYNC_STAGES(2)) uut (
    .bus_clk(bus_clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .cs(cs),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  // {req[20:17], is_read[16], addr[15:8], data_or_expect[7:0]}
  localparam int NVEC = 32;
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 8'h06, 8'h50},   // R3 low byte of reload value
    {4'd3,  1'b1, 8'h06, 8'h50},   // R3
    {4'd3,  1'b0, 8'h07, 8'hC3},   // R3 high byte
    {4'd3,  1'b1, 8'h07, 8'hC3},   // R3
    {4'd3,  1'b1, 8'h04, 8'h00},   // R3 counter untouched
    {4'd2,  1'b0, 8'h34, 8'h51},   // R2 mirror of offset 4
    {4'd2,  1'b1, 8'hF6, 8'h51},   // R2 mirror of offset 6
    {4'd4,  1'b0, 8'h05, 8'hC3},   // R4 start
    {4'd4,  1'b1, 8'h04, 8'h51},   // R4 counter low from reload
    {4'd2,  1'b1, 8'h85, 8'hC3},   // R2 mirror of offset 5
    {4'd4,  1'b1, 8'h07, 8'hC3},   // R4 reload high written too
    {4'd12, 1'b0, 8'h00, 8'hA5},   // R12 storage
    {4'd2,  1'b1, 8'h10, 8'hA5},   // R2 mirror of offset 0
    {4'd12, 1'b0, 8'h0F, 8'h3C},   // R12
    {4'd12, 1'b1, 8'h1F, 8'h3C},   // R12
    {4'd12, 1'b0, 8'h08, 8'h77},   // R12
    {4'd12, 1'b1, 8'h08, 8'h77},   // R12
    {4'd12, 1'b0, 8'h0C, 8'h12},   // R12
    {4'd12, 1'b1, 8'h0C, 8'h12},   // R12
    {4'd12, 1'b1, 8'h00, 8'hA5},   // R12 bytes independent
    {4'd12, 1'b1, 8'h04, 8'h51},   // R12 counter undisturbed
    {4'd10, 1'b0, 8'h0E, 8'hC0},   // R10 set enable
    {4'd10, 1'b1, 8'h0E, 8'hC0},   // R10
    {4'd10, 1'b0, 8'h0E, 8'h40},   // R10 clear enable
    {4'd10, 1'b1, 8'h0E, 8'h80},   // R10
    {4'd10, 1'b0, 8'h0E, 8'h83},   // R10 set two others
    {4'd10, 1'b1, 8'h0E, 8'h83},   // R10
    {4'd10, 1'b0, 8'h0E, 8'h7F},   // R10 clear all
    {4'd10, 1'b1, 8'h0E, 8'h80},   // R10
    {4'd12, 1'b0, 8'h0B, 8'h40},   // R12 auxiliary register, free-run
    {4'd12, 1'b1, 8'h0B, 8'h40},   // R12
    {4'd9,  1'b1, 8'h0D, 8'h00}    // R9 no flag yet
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    cs = 1'b1; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge bus_clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge bus_clk);
    cs = 1'b1; rd_en = 1'b1; wr_en = 1'b0; addr = a;
    #2 v = rdata;
    @(negedge bus_clk);
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      tmr_clk = 1'b1;
      repeat (5) @(negedge bus_clk);
      tmr_clk = 1'b0;
      repeat (5) @(negedge bus_clk);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge bus_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);

    // R1 reset state
    rd_chk("R1 cnt lo", 8'h04, 8'h00);
    rd_chk("R1 cnt hi", 8'h05, 8'h00);
    rd_chk("R1 reload lo", 8'h06, 8'h00);
    rd_chk("R1 flags", 8'h0D, 8'h00);
    rd_chk("R1 enables", 8'h0E, 8'h80);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][16]) rd_chk($sformatf("R%0d vec%0d", VEC[i][20:17], i), VEC[i][15:8], VEC[i][7:0]);
      else            wr(VEC[i][15:8], VEC[i][7:0]);
    end
    check("R12 irq_n after table", {7'd0, irq_n}, 8'h01);

    // R5 stepping
    wr(8'h06, 8'h03);
    wr(8'h05, 8'h00);
    pulse(1);
    rd_chk("R5 lo after one edge", 8'h04, 8'h02);
    rd_chk("R5 hi", 8'h05, 8'h00);

    // R6 free-run reload
    pulse(2);
    rd_chk("R6 no flag at zero", 8'h0D, 8'h00);
    pulse(1);
    rd_chk("R6 flag on reload", 8'h0D, 8'h40);
    check("R11 masked irq_n", {7'd0, irq_n}, 8'h01);
    rd_chk("R8 hi read keeps", 8'h05, 8'h00);
    rd_chk("R8 flag kept", 8'h0D, 8'h40);
    wr(8'h0E, 8'hC0);
    rd_chk("R11 summary bit", 8'h0D, 8'hC0);
    check("R11 irq_n low", {7'd0, irq_n}, 8'h00);
    rd_chk("R8 reloaded count via mirror", 8'hA4, 8'h03);
    rd_chk("R8 flag cleared", 8'h0D, 8'h00);
    check("R11 irq_n released", {7'd0, irq_n}, 8'h01);
    pulse(3);
    rd_chk("R6 period not yet", 8'h0D, 8'h00);
    pulse(1);
    rd_chk("R6 period reload+1", 8'h0D, 8'hC0);

    // R9 flag write clears
    wr(8'h0D, 8'h3F);
    rd_chk("R9 zeros keep flag", 8'h0D, 8'hC0);
    wr(8'h0D, 8'h40);
    rd_chk("R9 one clears flag", 8'h0D, 8'h00);
    check("R9 irq_n", {7'd0, irq_n}, 8'h01);

    // R4 start clears flag
    pulse(4);
    rd_chk("R4 flag before start", 8'h0D, 8'hC0);
    wr(8'h05, 8'h00);
    rd_chk("R4 start clears flag", 8'h0D, 8'h00);

    // R7 one-shot
    wr(8'h0B, 8'h00);
    wr(8'h06, 8'h02);
    wr(8'h05, 8'h00);
    pulse(2);
    rd_chk("R7 zero no flag", 8'h0D, 8'h00);
    pulse(1);
    rd_chk("R7 flag once", 8'h0D, 8'hC0);
    rd_chk("R7 wrap hi", 8'h05, 8'hFF);
    rd_chk("R7 wrap lo", 8'h04, 8'hFF);
    pulse(1);
    rd_chk("R7 keeps falling", 8'h04, 8'hFE);
    rd_chk("R7 no second flag", 8'h0D, 8'h00);
    check("R7 irq_n", {7'd0, irq_n}, 8'h01);
    wr(8'h05, 8'h00);
    pulse(3);
    rd_chk("R7 restart rearms", 8'h0D, 8'hC0);

    // R1 reset in the middle of a run
    @(negedge bus_clk);
    rst_n = 1'b0;
    #2 check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rd_chk("R1 flags in reset", 8'h0D, 8'h00);
    rd_chk("R1 enables in reset", 8'h0E, 8'h80);

    done = 1'b1;
    finish_run();
  end
endmodule